// File: doc/BRIEF.md
# Destination Tag Reader and FIFO Drain

This block is the receive end of a word-oriented transfer channel. Words come from a shared FIFO that shows its head word and an occupancy count. The block does not get its destination or length from any register. It reads them from the word stream. Each transfer starts with a four-word destination tag:

- The first tag word gives a byte address and the end conditions.
- The second tag word gives a payload length in words.
- The remaining two tag words are thrown away.

The payload words that follow are written one by one to a simple memory write port, at addresses that step by four bytes.

When the payload of a tag has been written and that tag was marked as the last one, the block stops. It drops its busy indication and pulses an interrupt. With the pulse it reports how many payload words were moved. That count is never reported as less than one. A tag without the end marking is followed directly by another tag.

Software or an upstream controller starts the block with a one-cycle start pulse. It learns of completion through the interrupt. The FIFO may run dry at any point, and the memory side may hold off writes. In both cases the block simply waits.

Top module: `dst_tag_drain`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_valid` and `fifo_pop` are all low.
- R2: A `start` pulse while idle sets `busy` on the next cycle. A `start` pulse while busy does not change the word stream written or the reported count.
- R3: A tag is read only when the current tag's payload is exhausted, the current tag is not end-marked, and `fifo_count` is at least 4. The block then pops exactly 4 words. With fewer than 4 words present it pops nothing.
- R4: The destination start address is bits [23:0] of tag word 0. Bits [27:24] of that word have no effect.
- R5: The payload length is bits [23:0] of tag word 1. Exactly that many writes follow the tag, including none for a length of zero.
- R6: Successive payload writes of a tag go to the start address plus 4 per word, wrapping modulo 2^24.
- R7: A tag is end-marked when bit 31 (interrupt flag) of word 0 is set, or bit 30 of word 0 is set (bit 2 of the 3-bit ID field in bits [30:28]). After an end-marked tag no further word is popped.
- R8: Each write carries the FIFO head word. A word is popped only in a cycle where `mem_valid` and `mem_ready` are both high. `mem_valid` stays low while the FIFO is empty. `mem_valid` holds with a stable address and data while `mem_ready` is low.
- R9: On completion, `busy` falls and `irq` is high for exactly one cycle, in the same cycle that `busy` is first low.
- R10: While `irq` is high, `xfer_words` equals the number of payload words written since `start`, or 1 if that number is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |
| xfer_words | output | TOT_W | Reported payload word count, valid with `irq` |
| fifo_count | input | OCC_W | Number of words held in the FIFO |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_pop | output | 1 | Removes the head word at the clock edge |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Write request accepted |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 32 | Write data |

## Verification
`busy` is due one clock after the edge that samples `start`. It is checked at the falling edge that follows.

Tag pops and payload writes have no fixed latency, because FIFO filling and `mem_ready` are random. The bench therefore checks writes by handshake. At each falling edge where both `mem_valid` and `mem_ready` are high, it compares address and data with the next expected entry. It also counts pops against the expected total.

The completion pulse is awaited at falling edges. In the cycle it appears, the bench checks `busy`, the reported count and that no writes remain. One cycle later it checks that the pulse has gone. After a further settle period it checks that the trailing word left in the FIFO was never taken.

// File: rtl/dst_tag_drain_pkg.sv
package dst_tag_drain_pkg;

  localparam int WORD_W     = 32;
  localparam int TAG_WORDS  = 4;
  localparam int IRQ_BIT    = 31;
  localparam int ID_LSB     = 28;
  localparam int ID_W       = 3;
  localparam int END_ID_BIT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAG  = 2'd2
  } drain_st_e;

  // End condition of a tag, taken from its first word.
  function automatic logic tag_ends(input logic [WORD_W-1:0] w0);
    logic [ID_W-1:0] id;
    id = w0[ID_LSB +: ID_W];
    return w0[IRQ_BIT] | id[END_ID_BIT];
  endfunction

endpackage

// File: rtl/dst_tag_capture.sv
module dst_tag_capture
  import dst_tag_drain_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WC_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              clr,
  input  logic [WORD_W-1:0] word_i,
  output logic              pop_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WC_W-1:0]   wc_o,
  output logic              end_o
);

  localparam int IDX_W = (TAG_WORDS > 1) ? $clog2(TAG_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAG_WORDS - 1);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WC_W-1:0]   wc_q;
  logic              end_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      addr_q   <= '0;
      wc_q     <= '0;
      end_q    <= 1'b0;
    end else if (go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      case (idx_q)
        IDX_W'(0): begin
          addr_q <= word_i[ADDR_W-1:0];
          end_q  <= tag_ends(word_i);
        end
        IDX_W'(1): wc_q <= word_i[WC_W-1:0];
        default: ;
      endcase
      idx_q <= idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) active_q <= 1'b0;
    end
  end

  assign pop_o  = active_q;
  assign done_o = active_q && (idx_q == LAST_IDX);
  assign addr_o = addr_q;
  assign wc_o   = wc_q;
  assign end_o  = end_q;

endmodule

// File: rtl/dst_payload_mover.sv
module dst_payload_mover #(
  parameter int ADDR_W = 24,
  parameter int WC_W   = 24,
  parameter int TOT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_tot,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WC_W-1:0]   load_wc,
  input  logic              accept,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rem_zero_o,
  output logic [TOT_W-1:0]  total_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] addr_q;
  logic [WC_W-1:0]   rem_q;
  logic [TOT_W-1:0]  tot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      rem_q  <= load_wc;
    end else if (accept) begin
      addr_q <= addr_q + STEP;
      rem_q  <= rem_q - WC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_tot) tot_q <= '0;
    else if (accept)      tot_q <= tot_q + TOT_W'(1);
  end

  assign addr_o     = addr_q;
  assign rem_zero_o = (rem_q == '0);
  assign total_o    = tot_q;

endmodule

// File: rtl/dst_tag_drain.sv
module dst_tag_drain
  import dst_tag_drain_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WC_W   = 24,
  parameter int OCC_W  = 6,
  parameter int TOT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              irq,
  output logic [TOT_W-1:0]  xfer_words,
  input  logic [OCC_W-1:0]  fifo_count,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_pop,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data
);

  localparam logic [OCC_W-1:0] TAG_NEED = OCC_W'(TAG_WORDS);

  drain_st_e         st_q;
  logic              busy_q, irq_q, end_q;
  logic [TOT_W-1:0]  xfer_q;

  logic              tag_go, tag_pop, tag_done, tag_end;
  logic [ADDR_W-1:0] tag_addr, pay_addr;
  logic [WC_W-1:0]   tag_wc;
  logic              rem_zero, accept, finish, begin_xfer;
  logic [TOT_W-1:0]  total;

  always_comb begin
    begin_xfer = (st_q == ST_IDLE) && start;
    mem_valid  = (st_q == ST_RUN) && !rem_zero && (fifo_count != '0);
    accept     = mem_valid && mem_ready;
    tag_go     = (st_q == ST_RUN) && rem_zero && !end_q && (fifo_count >= TAG_NEED);
    finish     = (st_q == ST_RUN) && rem_zero && end_q;
    fifo_pop   = tag_pop || accept;
  end

  dst_tag_capture #(.ADDR_W(ADDR_W), .WC_W(WC_W)) u_tag (
    .clk    (clk),
    .rst    (rst),
    .go     (tag_go),
    .clr    (finish),
    .word_i (fifo_rdata),
    .pop_o  (tag_pop),
    .done_o (tag_done),
    .addr_o (tag_addr),
    .wc_o   (tag_wc),
    .end_o  (tag_end)
  );

  dst_payload_mover #(.ADDR_W(ADDR_W), .WC_W(WC_W), .TOT_W(TOT_W)) u_pay (
    .clk        (clk),
    .rst        (rst),
    .clear_tot  (begin_xfer),
    .load       (tag_done),
    .load_addr  (tag_addr),
    .load_wc    (tag_wc),
    .accept     (accept),
    .addr_o     (pay_addr),
    .rem_zero_o (rem_zero),
    .total_o    (total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      end_q  <= 1'b0;
      xfer_q <= '0;
    end else begin
      irq_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_RUN;
            busy_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (finish) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            end_q  <= 1'b0;
            xfer_q <= (total == '0) ? TOT_W'(1) : total;
          end else if (tag_go) begin
            st_q <= ST_TAG;
          end
        end
        ST_TAG: begin
          if (tag_done) begin
            st_q  <= ST_RUN;
            end_q <= tag_end;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign irq        = irq_q;
  assign xfer_words = xfer_q;
  assign mem_addr   = pay_addr;
  assign mem_data   = fifo_rdata;

endmodule

// File: rtl/dst_tag_drain_chk.sv
module dst_tag_drain_chk #(
  parameter int ADDR_W = 24,
  parameter int OCC_W  = 6,
  parameter int TOT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              irq,
  input logic [TOT_W-1:0]  xfer_words,
  input logic [OCC_W-1:0]  fifo_count,
  input logic              fifo_pop,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data
);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!fifo_pop && !mem_valid)); // R3

  AST_VALID_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy); // R5

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (fifo_count != '0)); // R8

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R8

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R9

  AST_END_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq); // R9

  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy); // R9

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    irq |-> (xfer_words != '0)); // R10

endmodule

bind dst_tag_drain dst_tag_drain_chk #(
  .ADDR_W(ADDR_W), .OCC_W(OCC_W), .TOT_W(TOT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .irq        (irq),
  .xfer_words (xfer_words),
  .fifo_count (fifo_count),
  .fifo_pop   (fifo_pop),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data)
);

// File: tb/dst_tag_drain_tb_top.sv
module dst_tag_drain_tb_top;
  localparam int ADDR_W = 24;
  localparam int WC_W   = 24;
  localparam int OCC_W  = 6;
  localparam int TOT_W  = 32;
  localparam int DEPTH  = 32;
  localparam logic [31:0] TRAILER = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, irq, fifo_pop, mem_valid;
  logic [TOT_W-1:0]  xfer_words;
  logic [OCC_W-1:0]  fifo_count = '0;
  logic [31:0]       fifo_rdata = '0;
  logic              mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_data;

  always #5 clk = ~clk;

  dst_tag_drain #(.ADDR_W(ADDR_W), .WC_W(WC_W), .OCC_W(OCC_W), .TOT_W(TOT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .irq(irq),
    .xfer_words(xfer_words), .fifo_count(fifo_count), .fifo_rdata(fifo_rdata),
    .fifo_pop(fifo_pop), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  logic [31:0]       fq[$];
  logic [31:0]       src_q[$];
  logic [ADDR_W-1:0] exp_a[$];
  logic [31:0]       exp_d[$];
  int  feed_pct = 100, ready_pct = 100;
  int  pops = 0, writes = 0, g_tags = 0, g_total = 0, cyc = 0;
  int  n_chk = 0, n_fail = 0;
  bit  pop_pend = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench FIFO, feeder and memory ready generator.
  always @(posedge clk) begin
    if (pop_pend && fq.size() > 0) begin
      void'(fq.pop_front());
      pops++;
    end
    if (src_q.size() > 0 && fq.size() < DEPTH && int'($urandom % 100) < feed_pct)
      fq.push_back(src_q.pop_front());
    fifo_count <= OCC_W'(fq.size());
    fifo_rdata <= (fq.size() > 0) ? fq[0] : 32'h0;
    mem_ready  <= int'($urandom % 100) < ready_pct;
  end

  // Falling-edge monitor of pops and accepted writes.
  always @(negedge clk) begin
    pop_pend = (fifo_pop === 1'b1);
    if (!rst && mem_valid === 1'b1 && mem_ready === 1'b1) begin
      writes++;
      if (exp_a.size() == 0) begin
        chk(1'b0, "R5", "unexpected write", longint'(mem_addr), 0);
      end else begin
        chk(mem_addr == exp_a[0], "R6", "write address", longint'(mem_addr), longint'(exp_a[0]));
        chk(mem_data == exp_d[0], "R8", "write data", longint'(mem_data), longint'(exp_d[0]));
        void'(exp_a.pop_front());
        void'(exp_d.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Queue one tag plus its payload; expectations from R4, R5, R6.
  task automatic add_tag(input logic [ADDR_W-1:0] a, input logic [3:0] junk,
                         input logic [2:0] id, input logic irqb, input int wc);
    logic [31:0] w0, w1;
    w0 = {irqb, id, junk, a};
    w1 = {8'($urandom), 24'(wc)};
    src_q.push_back(w0);
    src_q.push_back(w1);
    src_q.push_back($urandom);
    src_q.push_back($urandom);
    for (int i = 0; i < wc; i++) begin
      logic [31:0] d;
      d = $urandom;
      src_q.push_back(d);
      exp_a.push_back(a + ADDR_W'(4 * i));
      exp_d.push_back(d);
    end
    g_tags++;
    g_total += wc;
  endtask

  task automatic pulse_start();
    @(posedge clk); start <= 1'b1;
    @(posedge clk); start <= 1'b0;
  endtask

  // Run the queued chain, check completion, leftover and pop count.
  task automatic run_xfer(input string name, input bit restart);
    int waited;
    bit seen;
    src_q.push_back(TRAILER);
    pops = 0;
    writes = 0;
    pulse_start();
    @(negedge clk);
    chk(busy == 1'b1, "R2", {name, " busy after start"}, busy, 1);
    waited = 0;
    seen = 1'b0;
    while (!seen && waited < 20000) begin
      if (restart && waited == 8) begin
        @(posedge clk); start <= 1'b1;
        @(posedge clk); start <= 1'b0;
        @(negedge clk);
      end
      if (irq === 1'b1) seen = 1'b1;
      else begin
        @(negedge clk);
        waited++;
      end
    end
    chk(seen, "R9", {name, " completion pulse"}, seen, 1);
    chk(busy == 1'b0, "R9", {name, " busy low with irq"}, busy, 0);
    chk(xfer_words == TOT_W'((g_total == 0) ? 1 : g_total), "R10", {name, " reported count"},
        xfer_words, (g_total == 0) ? 1 : g_total);
    chk(exp_a.size() == 0, "R5", {name, " writes outstanding"}, exp_a.size(), 0);
    @(negedge clk);
    chk(irq == 1'b0, "R9", {name, " irq one cycle"}, irq, 0);
    feed_pct = 100;
    repeat (40) @(negedge clk);
    chk(fq.size() == 1 && fq[0] == TRAILER, "R7", {name, " trailer untouched"}, fq.size(), 1);
    chk(pops == 4 * g_tags + g_total, "R3", {name, " pop count"}, pops, 4 * g_tags + g_total);
    fq.delete();
    src_q.delete();
    exp_a.delete();
    exp_d.delete();
    g_tags = 0;
    g_total = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && irq == 0 && mem_valid == 0 && fifo_pop == 0, "R1", "reset state",
        {busy, irq, mem_valid, fifo_pop}, 0);
    @(posedge clk); rst <= 1'b0;

    // R4 R6 R7: junk bits 27:24, wrap past top, ID 3 is not an end, then ID 4 ends.
    add_tag(24'hFFFFF8, 4'hF, 3'b011, 1'b0, 4);
    add_tag(24'h000100, 4'h0, 3'b100, 1'b0, 2);
    run_xfer("wrap", 1'b0);

    // R7 interrupt-flag end, R2 start while busy.
    ready_pct = 40;
    add_tag(24'h123450, 4'hA, 3'b000, 1'b1, 9);
    run_xfer("irqend", 1'b1);
    ready_pct = 100;

    // R10: zero-length end tag reports one.
    add_tag(24'h000040, 4'h0, 3'b110, 1'b0, 0);
    run_xfer("zerolen", 1'b0);

    // R3: three tag words only -> nothing popped.
    src_q.push_back({1'b1, 3'b000, 4'h0, 24'h000200});
    src_q.push_back(32'd1);
    src_q.push_back(32'h0);
    pops = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(pops == 0 && busy == 1'b1, "R3", "short tag not read", pops, 0);
    src_q.push_back(32'h0);
    src_q.push_back(32'h5A5A_0001);
    exp_a.push_back(24'h000200);
    exp_d.push_back(32'h5A5A_0001);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0 && busy == 1'b0 && exp_a.size() == 0, "R8", "short tag completes",
        exp_a.size(), 0);
    fq.delete(); src_q.delete();
    repeat (3) @(negedge clk);

    // Random chains.
    for (int it = 0; it < 10; it++) begin
      int nt;
      nt = 1 + int'($urandom % 4);
      feed_pct  = 20 + int'($urandom % 81);
      ready_pct = 30 + int'($urandom % 71);
      for (int t = 0; t < nt; t++) begin
        logic last, by_irq;
        last = (t == nt - 1);
        by_irq = $urandom % 2;
        add_tag(24'($urandom) & 24'hFFFFFC, 4'($urandom),
                {last & ~by_irq, 2'($urandom)}, last & by_irq, int'($urandom % 25));
      end
      run_xfer("random", it == 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule